// File: doc/BRIEF.md
# Message Interrupt Best-Pending Scanner

This block keeps track of the most urgent message-based interrupt for one processor. Such interrupts have IDs from 8192 upward. Their pending state lives in a bitmap in memory, one bit per ID. Their enable bit and priority live in a second table in memory, one byte per ID. The block reaches both tables through a byte-wide port that allows one access at a time. It publishes the best ID and its priority. A priority of 0xFF means nothing is pending.

Three events start work. When the enable input goes high, the block runs a full rescan of the tables. A set request marks one ID pending and then compares that single ID against the current best. A clear request removes one ID's pending bit. If that ID was the current best, a full rescan follows.

The base addresses of both tables, the table size code, the global enable and the security-disable flag are all plain inputs. While a scan or an update is in progress, `busy_o` is high and new requests are not accepted.

Top module: `lpi_hpp_scanner`

## Requirements
- R1: After reset, `best_prio_o` is 0xFF, `best_id_o` is 0, `busy_o` is 0 and no memory access is requested.
- R2: A rise of `lpi_en_i` starts a full rescan. The rescan first sets the best to 0xFF/0. It then reads pending-table bytes `pend_base_i + k`, one read per byte, for k from 1024 up to 2^(E+1)/8 − 1, where E is the effective size code. For each byte it handles the set bits from bit 0 upward. Bit b of byte k is ID 8k+b.
- R3: For each pending ID, the block reads one configuration byte at `cfg_base_i + (ID − 8192)`. Bit 0 of that byte is the enable, and entries with bit 0 clear are skipped. The priority field is the byte with its two low bits forced to zero.
- R4: When `sec_dis_i` is 1, the effective priority equals the field. Otherwise it is (field >> 1) | 0x80.
- R5: A candidate becomes the best when its priority is numerically lower than the best's. It also becomes the best when the priorities are equal and its ID is less than or equal to the best ID. As a result, the lowest ID wins ties.
- R6: While `lpi_en_i` is 0, requests are ignored and no memory access is made.
- R7: Requests with an ID below 8192 or above 2^(E+1) − 1 are ignored and make no memory access.
- R8: A set or clear request first reads the byte at `pend_base_i + ID/8`; the target is bit ID mod 8. The block writes the modified byte back only when that bit actually changes. When the bit is already in the requested state, there is no write and no further work.
- R9: A set that changes the bit is followed by exactly one configuration read for that ID and one comparison under R5. No pending-table scan takes place.
- R10: A clear that changes the bit starts a full rescan only if the ID equals `best_id_o`. Otherwise the best is left unchanged.
- R11: `mem_req_o` stays high, with its address, direction and write data stable, until `mem_ack_i`. `busy_o` is high while any work is in progress or pending. A request is taken only in a cycle where `req_valid_i` is high and `busy_o` is low.
- R12: The effective size code E is the smaller of `id_bits_i` and ID_W − 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lpi_en_i | input | 1 | Global enable; a rise starts a rescan |
| sec_dis_i | input | 1 | 1: priorities are used unshifted |
| id_bits_i | input | 5 | Table size code (IDs = 2^(code+1)) |
| pend_base_i | input | ADDR_W | Pending bitmap base address |
| cfg_base_i | input | ADDR_W | Configuration table base address |
| req_valid_i | input | 1 | Set/clear request strobe |
| req_set_i | input | 1 | 1 = set pending, 0 = clear |
| req_id_i | input | ID_W | Request interrupt ID |
| busy_o | output | 1 | Work in progress or queued |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | 1 = write |
| mem_addr_o | output | ADDR_W | Byte address |
| mem_wdata_o | output | 8 | Write data |
| mem_ack_i | input | 1 | Access complete; read data valid |
| mem_rdata_i | input | 8 | Read data |
| best_id_o | output | ID_W | Best pending ID |
| best_prio_o | output | 8 | Best priority, 0xFF = none |

## Verification
The full scan is run over a table that contains several kinds of entry: a disabled entry with the lowest field, two enabled entries with equal priority, and entries spread across distant bytes. This shows whether the enable bit, the tie rule and the byte walk are each applied correctly. The same table is scanned again with the security flag cleared, which separates the two priority mappings. A third scan uses an oversized size code to show the clamp, seen through the count of pending-byte reads.

The incremental paths are checked separately. These include a set that is better than the best, a set that is worse, a set that ties with a lower ID, a set of a bit that is already set, a clear of a non-best ID and a clear of the best. The access counts for each show apart the compare-only path, the skipped write-back and the rescan. Memory latency is varied so that handshake holding is exercised.

// File: rtl/lpi_scan_pkg.sv
package lpi_scan_pkg;
  localparam int unsigned LPI_FIRST_ID = 8192;
  localparam logic [7:0] PRIO_NONE = 8'hFF;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SCAN_NEXT, ST_SCAN_PRD, ST_SCAN_BIT,
    ST_SCAN_CRD, ST_UPD_RD, ST_UPD_WR, ST_UPD_CRD
  } state_e;
endpackage

// File: rtl/lpi_bit_pick.sv
module lpi_bit_pick #(
  parameter int W  = 8,
  localparam int IW = $clog2(W)
) (
  input  logic [W-1:0]  vec_i,
  output logic [IW-1:0] idx_o,
  output logic          any_o
);
  always_comb begin
    idx_o = '0;
    for (int i = W - 1; i >= 0; i--)
      if (vec_i[i]) idx_o = IW'(i);
  end
  assign any_o = |vec_i;
endmodule

// File: rtl/lpi_prio_map.sv
module lpi_prio_map (
  input  logic [7:0] cfg_i,
  input  logic       sec_dis_i,
  output logic       en_o,
  output logic [7:0] prio_o
);
  logic [7:0] field;
  assign field  = {cfg_i[7:2], 2'b00};
  assign en_o   = cfg_i[0];
  assign prio_o = sec_dis_i ? field : {1'b1, field[7:1]};
endmodule

// File: rtl/lpi_best_cmp.sv
module lpi_best_cmp #(
  parameter int ID_W = 16
) (
  input  logic [7:0]      cand_prio_i,
  input  logic [ID_W-1:0] cand_id_i,
  input  logic [7:0]      best_prio_i,
  input  logic [ID_W-1:0] best_id_i,
  output logic            take_o
);
  assign take_o = (cand_prio_i < best_prio_i) ||
                  ((cand_prio_i == best_prio_i) && (cand_id_i <= best_id_i));
endmodule

// File: rtl/lpi_hpp_scanner.sv
module lpi_hpp_scanner
  import lpi_scan_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int ID_W   = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lpi_en_i,
  input  logic              sec_dis_i,
  input  logic [4:0]        id_bits_i,
  input  logic [ADDR_W-1:0] pend_base_i,
  input  logic [ADDR_W-1:0] cfg_base_i,
  input  logic              req_valid_i,
  input  logic              req_set_i,
  input  logic [ID_W-1:0]   req_id_i,
  output logic              busy_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [7:0]        mem_wdata_o,
  input  logic              mem_ack_i,
  input  logic [7:0]        mem_rdata_i,
  output logic [ID_W-1:0]   best_id_o,
  output logic [7:0]        best_prio_o
);
  localparam int BYTE_W   = ID_W - 3;
  localparam int MAX_BITS = ID_W - 1;
  localparam logic [BYTE_W:0] FIRST_BYTE = (BYTE_W+1)'(LPI_FIRST_ID / 8);
  localparam logic [ID_W-1:0] FIRST_ID   = ID_W'(LPI_FIRST_ID);

  state_e            state;
  logic [BYTE_W:0]   byte_idx;
  logic [7:0]        bits_q, pend_byte_q;
  logic [ID_W-1:0]   cur_id, req_id_q;
  logic              req_set_q, en_q, rescan_pend;

  logic [4:0]        eff_bits;
  logic [BYTE_W:0]   byte_end;
  logic [ID_W:0]     id_max;
  logic              req_ok;
  logic [2:0]        pick_idx;
  logic              pick_any;
  logic              cfg_en, take;
  logic [7:0]        cand_prio;
  logic [ID_W-1:0]   cfg_off;

  assign eff_bits = (id_bits_i > 5'(MAX_BITS)) ? 5'(MAX_BITS) : id_bits_i;
  assign byte_end = (eff_bits >= 5'd2) ? ((BYTE_W+1)'(1) << (eff_bits - 5'd2)) : '0;
  assign id_max   = ((ID_W+1)'(1) << (eff_bits + 5'd1)) - (ID_W+1)'(1);
  assign req_ok   = lpi_en_i && (req_id_i >= FIRST_ID) && ({1'b0, req_id_i} <= id_max);
  assign cfg_off  = cur_id - FIRST_ID;

  lpi_bit_pick #(.W(8)) u_pick (.vec_i(bits_q), .idx_o(pick_idx), .any_o(pick_any));

  lpi_prio_map u_map (
    .cfg_i(mem_rdata_i), .sec_dis_i(sec_dis_i), .en_o(cfg_en), .prio_o(cand_prio)
  );

  lpi_best_cmp #(.ID_W(ID_W)) u_cmp (
    .cand_prio_i(cand_prio), .cand_id_i(cur_id),
    .best_prio_i(best_prio_o), .best_id_i(best_id_o), .take_o(take)
  );

  assign busy_o      = (state != ST_IDLE) || rescan_pend;
  assign mem_req_o   = (state == ST_SCAN_PRD) || (state == ST_SCAN_CRD) ||
                       (state == ST_UPD_RD) || (state == ST_UPD_WR) || (state == ST_UPD_CRD);
  assign mem_we_o    = (state == ST_UPD_WR);
  assign mem_wdata_o = pend_byte_q;

  always_comb begin
    unique case (state)
      ST_SCAN_PRD:             mem_addr_o = pend_base_i + ADDR_W'(byte_idx);
      ST_SCAN_CRD, ST_UPD_CRD: mem_addr_o = cfg_base_i + ADDR_W'(cfg_off);
      ST_UPD_RD, ST_UPD_WR:    mem_addr_o = pend_base_i + ADDR_W'(req_id_q[ID_W-1:3]);
      default:                 mem_addr_o = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state       <= ST_IDLE;
      byte_idx    <= '0;
      bits_q      <= '0;
      pend_byte_q <= '0;
      cur_id      <= '0;
      req_id_q    <= '0;
      req_set_q   <= 1'b0;
      en_q        <= 1'b0;
      rescan_pend <= 1'b0;
      best_id_o   <= '0;
      best_prio_o <= PRIO_NONE;
    end else begin
      en_q <= lpi_en_i;
      unique case (state)
        ST_IDLE: begin
          if (rescan_pend) begin
            rescan_pend <= 1'b0;
            if (lpi_en_i) begin
              best_prio_o <= PRIO_NONE;
              best_id_o   <= '0;
              byte_idx    <= FIRST_BYTE;
              state       <= ST_SCAN_NEXT;
            end
          end else if (req_valid_i && req_ok) begin
            req_id_q  <= req_id_i;
            req_set_q <= req_set_i;
            state     <= ST_UPD_RD;
          end
        end
        ST_SCAN_NEXT: state <= (byte_idx < byte_end) ? ST_SCAN_PRD : ST_IDLE;
        ST_SCAN_PRD: if (mem_ack_i) begin
          bits_q <= mem_rdata_i;
          state  <= ST_SCAN_BIT;
        end
        ST_SCAN_BIT: begin
          if (pick_any) begin
            cur_id <= {byte_idx[BYTE_W-1:0], pick_idx};
            bits_q <= bits_q & ~(8'h01 << pick_idx);
            state  <= ST_SCAN_CRD;
          end else begin
            byte_idx <= byte_idx + 1'b1;
            state    <= ST_SCAN_NEXT;
          end
        end
        ST_SCAN_CRD: if (mem_ack_i) begin
          if (cfg_en && take) begin
            best_prio_o <= cand_prio;
            best_id_o   <= cur_id;
          end
          state <= ST_SCAN_BIT;
        end
        ST_UPD_RD: if (mem_ack_i) begin
          if (mem_rdata_i[req_id_q[2:0]] == req_set_q) state <= ST_IDLE;
          else begin
            pend_byte_q <= mem_rdata_i ^ (8'h01 << req_id_q[2:0]);
            state       <= ST_UPD_WR;
          end
        end
        ST_UPD_WR: if (mem_ack_i) begin
          if (req_set_q) begin
            cur_id <= req_id_q;
            state  <= ST_UPD_CRD;
          end else if (req_id_q == best_id_o) begin
            best_prio_o <= PRIO_NONE;
            best_id_o   <= '0;
            byte_idx    <= FIRST_BYTE;
            state       <= ST_SCAN_NEXT;
          end else state <= ST_IDLE;
        end
        ST_UPD_CRD: if (mem_ack_i) begin
          if (cfg_en && take) begin
            best_prio_o <= cand_prio;
            best_id_o   <= cur_id;
          end
          state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
      if (lpi_en_i && !en_q) rescan_pend <= 1'b1;
    end
  end
endmodule

// File: rtl/lpi_hpp_scanner_chk.sv
module lpi_hpp_scanner_chk #(
  parameter int ADDR_W = 32,
  parameter int ID_W   = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              lpi_en_i,
  input logic              sec_dis_i,
  input logic [4:0]        id_bits_i,
  input logic [ADDR_W-1:0] pend_base_i,
  input logic [ADDR_W-1:0] cfg_base_i,
  input logic              req_valid_i,
  input logic              req_set_i,
  input logic [ID_W-1:0]   req_id_i,
  input logic              busy_o,
  input logic              mem_req_o,
  input logic              mem_we_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [7:0]        mem_wdata_o,
  input logic              mem_ack_i,
  input logic [7:0]        mem_rdata_i,
  input logic [ID_W-1:0]   best_id_o,
  input logic [7:0]        best_prio_o
);
  // R11
  mem_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o) &&
                                $stable(mem_we_o) && $stable(mem_wdata_o));
  // R11
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !mem_req_o);
  // R6
  dis_ignore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && req_valid_i && !lpi_en_i |=> !mem_req_o);
  // R7
  low_id_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && req_valid_i && (req_id_i < ID_W'(8192)) |=> !mem_req_o);
  // R3
  prio_lsb_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    best_prio_o != 8'hFF |-> best_prio_o[0] == 1'b0);
endmodule

bind lpi_hpp_scanner lpi_hpp_scanner_chk #(.ADDR_W(ADDR_W), .ID_W(ID_W)) u_chk (.*);

// File: tb/tb_lpi_hpp_scanner.sv
module tb_lpi_hpp_scanner;
  localparam int ADDR_W = 32;
  localparam int ID_W   = 15;
  localparam logic [31:0] PB = 32'h0001_0000;
  localparam logic [31:0] CB = 32'h0002_0000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic lpi_en = 1'b0, sec_dis = 1'b1, req_valid = 1'b0, req_set = 1'b0;
  logic [4:0] id_bits = 5'd13;
  logic [ID_W-1:0] req_id = '0;
  logic busy, mem_req, mem_we, mem_ack = 1'b0;
  logic [ADDR_W-1:0] mem_addr;
  logic [7:0] mem_wdata, mem_rdata = 8'h00;
  logic [ID_W-1:0] best_id;
  logic [7:0] best_prio;

  logic [7:0] pend_mem [0:4095];
  logic [7:0] cfg_mem  [0:8191];
  int n_prd, n_crd, n_wr, n_bad, lat, wcnt;
  int n_chk = 0, n_err = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  lpi_hpp_scanner #(.ADDR_W(ADDR_W), .ID_W(ID_W)) dut (
    .clk_i(clk), .rst_ni(rst_n), .lpi_en_i(lpi_en), .sec_dis_i(sec_dis),
    .id_bits_i(id_bits), .pend_base_i(PB), .cfg_base_i(CB),
    .req_valid_i(req_valid), .req_set_i(req_set), .req_id_i(req_id),
    .busy_o(busy), .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_ack_i(mem_ack), .mem_rdata_i(mem_rdata),
    .best_id_o(best_id), .best_prio_o(best_prio)
  );

  initial begin
    wcnt = 0;
    forever begin
      @(negedge clk);
      if (mem_ack) mem_ack = 1'b0;
      else if (mem_req) begin
        if (wcnt < lat) wcnt++;
        else begin
          wcnt = 0;
          if (mem_addr >= PB && mem_addr < PB + 4096) begin
            if (mem_we) begin pend_mem[mem_addr - PB] = mem_wdata; n_wr++; end
            else begin mem_rdata = pend_mem[mem_addr - PB]; n_prd++; end
          end else if (!mem_we && mem_addr >= CB && mem_addr < CB + 8192) begin
            mem_rdata = cfg_mem[mem_addr - CB]; n_crd++;
          end else n_bad++;
          mem_ack = 1'b1;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic clr_cnt();
    n_prd = 0; n_crd = 0; n_wr = 0; n_bad = 0;
  endtask

  function automatic void ref_best(input int max_id, output int bp, output int bid);
    bp = 255; bid = 0;
    for (int id = 8192; id <= max_id; id++)
      if (pend_mem[id >> 3][id & 7] && cfg_mem[id - 8192][0]) begin
        int f, p;
        f = cfg_mem[id - 8192] & 8'hFC;
        p = sec_dis ? f : ((f >> 1) | 8'h80);
        if (p < bp) begin bp = p; bid = id; end
      end
  endfunction

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic rescan();
    @(negedge clk); lpi_en = 1'b0;
    @(negedge clk); lpi_en = 1'b1;
    @(negedge clk);
    chk(busy == 1'b1, "R11 busy after enable rise", busy, 1);
    wait_idle();
  endtask

  task automatic issue(input bit s, input int id, input bit exp_busy);
    @(negedge clk); req_valid = 1'b1; req_set = s; req_id = ID_W'(id);
    @(negedge clk); req_valid = 1'b0;
    chk(busy == exp_busy, "R11 busy after request", busy, exp_busy);
    wait_idle();
  endtask

  task automatic pset(input int id, input bit v);
    pend_mem[id >> 3][id & 7] = v;
  endtask

  task automatic t_reset();
    chk(best_prio == 8'hFF, "R1 prio in reset", best_prio, 255);
    chk(best_id == '0, "R1 id in reset", best_id, 0);
    chk(!busy && !mem_req, "R1 idle in reset", {busy, mem_req}, 0);
  endtask

  task automatic t_full_scan();
    int bp, bid;
    pset(8200, 1);  cfg_mem[8]    = 8'h41;
    pset(9000, 1);  cfg_mem[808]  = 8'h04;
    pset(12000, 1); cfg_mem[3808] = 8'h31;
    pset(15000, 1); cfg_mem[6808] = 8'h31;
    pset(16383, 1); cfg_mem[8191] = 8'h35;
    sec_dis = 1'b1; lat = 0;
    clr_cnt(); rescan();
    ref_best(16383, bp, bid);
    chk(n_prd == 1024, "R2 pending byte reads", n_prd, 1024);
    chk(n_crd == 5, "R3 one cfg read per pending id", n_crd, 5);
    chk(best_prio == bp && best_id == bid, "R3 best vs model", {best_id, best_prio}, {bid[15:0], bp[7:0]});
    chk(best_id == 12000 && best_prio == 8'h30, "R5 tie to lower id, disabled skipped", best_id, 12000);
    chk(n_bad == 0, "R2 no stray address", n_bad, 0);
  endtask

  task automatic t_remap();
    sec_dis = 1'b0; lat = 2;
    clr_cnt(); rescan();
    chk(best_prio == 8'h98 && best_id == 12000, "R4 shifted priority", best_prio, 8'h98);
    lat = 0;
  endtask

  task automatic t_set();
    cfg_mem[1808] = 8'h21;
    clr_cnt(); issue(1'b1, 10000, 1'b1);
    chk(pend_mem[1250][0] == 1'b1 && n_wr == 1, "R8 set writes bit", n_wr, 1);
    chk(n_prd == 1 && n_crd == 1, "R9 single compare", n_prd * 16 + n_crd, 17);
    chk(best_id == 10000 && best_prio == 8'h90, "R9 better set wins", best_id, 10000);
    clr_cnt(); issue(1'b1, 10000, 1'b1);
    chk(n_wr == 0 && n_crd == 0, "R8 unchanged bit no write", n_wr, 0);
    cfg_mem[2808] = 8'h81;
    clr_cnt(); issue(1'b1, 11000, 1'b1);
    chk(best_id == 10000 && best_prio == 8'h90, "R9 worse set ignored", best_id, 10000);
    cfg_mem[1308] = 8'h21;
    clr_cnt(); issue(1'b1, 9500, 1'b1);
    chk(best_id == 9500 && best_prio == 8'h90, "R5 equal prio lower id", best_id, 9500);
  endtask

  task automatic t_clear();
    int bp, bid;
    clr_cnt(); issue(1'b0, 11000, 1'b1);
    chk(n_prd == 1 && n_wr == 1 && best_id == 9500, "R10 clear non-best keeps best", n_prd, 1);
    chk(pend_mem[1375][0] == 1'b0, "R8 clear writes bit", pend_mem[1375], 0);
    clr_cnt(); issue(1'b0, 9500, 1'b1);
    ref_best(16383, bp, bid);
    chk(n_prd == 1025, "R10 clear best rescans", n_prd, 1025);
    chk(best_id == bid && best_prio == bp, "R10 best after rescan", best_id, bid);
    clr_cnt(); issue(1'b0, 14000, 1'b1);
    chk(n_wr == 0 && n_prd == 1, "R8 clear of clear bit no write", n_wr, 0);
  endtask

  task automatic t_disabled();
    @(negedge clk); lpi_en = 1'b0;
    clr_cnt(); issue(1'b1, 14000, 1'b0);
    chk(n_prd + n_wr + n_crd == 0 && pend_mem[1750][0] == 1'b0, "R6 disabled no access", n_prd + n_wr, 0);
    rescan();
  endtask

  task automatic t_range();
    clr_cnt(); issue(1'b1, 100, 1'b0);
    chk(n_prd + n_wr + n_crd == 0, "R7 low id ignored", n_prd, 0);
    clr_cnt(); issue(1'b1, 16384, 1'b0);
    chk(n_prd + n_wr + n_crd == 0, "R7 high id ignored", n_prd, 0);
  endtask

  task automatic t_clamp();
    int bp, bid;
    id_bits = 5'd20;
    clr_cnt(); rescan();
    ref_best(32767, bp, bid);
    chk(n_prd == 3072, "R12 clamped table size", n_prd, 3072);
    chk(best_id == bid && best_prio == bp, "R12 best after clamp scan", best_id, bid);
    id_bits = 5'd13;
  endtask

  initial begin
    for (int i = 0; i < 4096; i++) pend_mem[i] = 8'h00;
    for (int i = 0; i < 8192; i++) cfg_mem[i] = 8'h00;
    lat = 0; clr_cnt();
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_full_scan();
    t_remap();
    t_set();
    t_clear();
    t_disabled();
    t_range();
    t_clamp();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_err++;
      $display("FAIL R11 watchdog expired actual=busy expected=idle");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
      $finish;
    end
  end
endmodule